// File: doc/BRIEF.md
# Locking Round-Robin Read Arbiter

This block joins several read-only bus masters onto one read slave port that uses AXI-style valid/ready channels. While idle it looks at the address-request valids of all masters and takes one in round-robin order. It then forwards only that master's read address to the slave. Once the address has been accepted, the block stays attached to the same master until the slave has delivered the final response beat, which is the beat marked last. Only after that beat does it arbitrate again.

Only one transaction is ever in flight, so the response channel needs no ID-based routing. Beats always belong to the locked master. The response payload (data, response code, last flag, ID) is driven to every master in parallel, and only the valid is gated per master. Masters that are not selected never see an address-ready or a response-valid. The block spends throughput in return for a very small amount of logic: one idle cycle between bursts, and no overlap of address and data traffic.

Top module: `rd_lock_arb`

## Requirements
- R1: After reset, with no master requesting, the slave address valid, slave response ready, every master address-ready and every master response-valid are all low.
- R2: Out of reset the round-robin pointer is port 0. The granted port is the first port that is requesting, searching upward from the pointer and wrapping past the highest index. After an address handshake the pointer moves to the granted port plus one, modulo the number of ports.
- R3: While a port is selected for its address phase, the slave sees that port's address, length and ID and that port's address valid. That port's address-ready mirrors the slave's address-ready, and the address-ready of every other port stays low.
- R4: From the slave address handshake until the response handshake that carries the last flag, the slave address valid stays low and the selection does not change.
- R5: During the response phase, the locked port's response valid equals the slave response valid, and every other port's response valid is low. Response data, code, last flag and ID reach all masters unchanged. A burst of length field L delivers L+1 beats.
- R6: One cycle after the last-flagged response handshake, the slave address valid is low (an idle cycle). If any master is requesting in that idle cycle, the slave address valid is high in the following cycle.
- R7: Ports whose address valid is low are skipped by the search and are never granted.
- R8: The response ready from a port that is not locked has no effect: the slave response ready equals the locked port's response ready alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| m_arvalid | input | NUM_PORTS | Address valid, one bit per master |
| m_arready | output | NUM_PORTS | Address ready, one bit per master |
| m_araddr | input | NUM_PORTS*ADDR_W | Read addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| m_arlen | input | NUM_PORTS*LEN_W | Burst length fields (beats minus one), packed per port |
| m_arid | input | NUM_PORTS*ID_W | Transaction IDs, packed per port |
| m_rvalid | output | NUM_PORTS | Response valid, one bit per master |
| m_rready | input | NUM_PORTS | Response ready, one bit per master |
| m_rdata | output | DATA_W | Response data, common to all masters |
| m_rresp | output | 2 | Response code, common to all masters |
| m_rlast | output | 1 | Last-beat flag, common to all masters |
| m_rid | output | ID_W | Response ID, common to all masters |
| s_arvalid | output | 1 | Address valid toward the slave |
| s_arready | input | 1 | Address ready from the slave |
| s_araddr | output | ADDR_W | Address toward the slave |
| s_arlen | output | LEN_W | Burst length field toward the slave |
| s_arid | output | ID_W | Transaction ID toward the slave |
| s_rvalid | input | 1 | Response valid from the slave |
| s_rready | output | 1 | Response ready toward the slave |
| s_rdata | input | DATA_W | Response data from the slave |
| s_rresp | input | 2 | Response code from the slave |
| s_rlast | input | 1 | Last-beat flag from the slave |
| s_rid | input | ID_W | Response ID from the slave |

## Verification
A request that shows up in an idle cycle reaches the slave address valid one clock later, because the grant is registered. An accepted address puts the block in its response phase from the next clock. A last-flagged beat returns it to idle one clock later, and a waiting request is forwarded one clock after that. The address-ready, response-valid and response-ready paths are combinational and apply within the same cycle. The bench samples every port at the falling edge, so a handshake it sees there is the one the next rising edge will take. It updates stimulus just after the rising edge, and it checks the idle gap and the re-request timing at exactly the first and second falling edges after the last beat. Grant order and address payload go through a queue of expected grants that the monitor pops on each slave address handshake.

// File: rtl/rd_arb_pkg.sv
package rd_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_ADDR = 2'd1,
    ARB_DATA = 2'd2
  } arb_state_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] req,
  input  logic [IDX_W-1:0]     ptr,
  output logic                 found,
  output logic [IDX_W-1:0]     win
);
  // Walk offsets from far to near so the nearest requester at or after ptr wins.
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_PORTS;
      if (req[IDX_W'(idx)]) begin
        found = 1'b1;
        win   = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import rd_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_found,
  input  logic [IDX_W-1:0] pick_win,
  input  logic             ar_hs,
  input  logic             r_end,
  output arb_state_e       st_q,
  output logic [IDX_W-1:0] sel_q,
  output logic [IDX_W-1:0] ptr_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

  arb_state_e       st_d;
  logic [IDX_W-1:0] sel_d;
  logic [IDX_W-1:0] ptr_d;
  logic             upd_en;

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    ptr_d = ptr_q;
    case (st_q)
      ARB_IDLE: begin
        if (pick_found) begin
          st_d  = ARB_ADDR;
          sel_d = pick_win;
        end
      end
      ARB_ADDR: begin
        if (ar_hs) begin
          st_d  = ARB_DATA;
          ptr_d = (sel_q == LAST_IDX) ? '0 : sel_q + IDX_W'(1);
        end
      end
      ARB_DATA: begin
        if (r_end) st_d = ARB_IDLE;
      end
      default: st_d = ARB_IDLE;
    endcase
  end

  assign upd_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ARB_IDLE;
      sel_q <= '0;
      ptr_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      sel_q <= sel_d;
      ptr_q <= ptr_d;
    end
  end

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_DATA && r_end) |=> (st_q == ARB_IDLE)); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ARB_IDLE) |=> $stable(sel_q)); // R4
  AST_PTR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_ADDR && ar_hs) |=>
      (ptr_q == (($past(sel_q) == LAST_IDX) ? '0 : $past(sel_q) + IDX_W'(1)))); // R2
  AST_DATA_ONLY_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ARB_DATA) |-> ($past(st_q) == ARB_ADDR)); // R4
endmodule

// File: rtl/rd_path_mux.sv
module rd_path_mux
  import rd_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int ID_W      = 4
) (
  input  arb_state_e                  st,
  input  logic [IDX_W-1:0]            sel,
  input  logic [NUM_PORTS-1:0]        m_arvalid,
  input  logic [NUM_PORTS*ADDR_W-1:0] m_araddr,
  input  logic [NUM_PORTS*LEN_W-1:0]  m_arlen,
  input  logic [NUM_PORTS*ID_W-1:0]   m_arid,
  input  logic [NUM_PORTS-1:0]        m_rready,
  input  logic                        s_arready,
  input  logic                        s_rvalid,
  output logic [NUM_PORTS-1:0]        m_arready,
  output logic [NUM_PORTS-1:0]        m_rvalid,
  output logic                        s_arvalid,
  output logic [ADDR_W-1:0]           s_araddr,
  output logic [LEN_W-1:0]            s_arlen,
  output logic [ID_W-1:0]             s_arid,
  output logic                        s_rready
);
  logic in_addr;
  logic in_data;

  assign in_addr = (st == ARB_ADDR);
  assign in_data = (st == ARB_DATA);

  assign s_arvalid = in_addr & m_arvalid[sel];
  assign s_araddr  = m_araddr[sel*ADDR_W +: ADDR_W];
  assign s_arlen   = m_arlen[sel*LEN_W +: LEN_W];
  assign s_arid    = m_arid[sel*ID_W +: ID_W];
  assign s_rready  = in_data & m_rready[sel];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic hit;
    assign hit          = (sel == IDX_W'(i));
    assign m_arready[i] = in_addr & hit & s_arready;
    assign m_rvalid[i]  = in_data & hit & s_rvalid;
  end
endmodule

// File: rtl/rd_lock_arb.sv
module rd_lock_arb
  import rd_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        m_arvalid,
  output logic [NUM_PORTS-1:0]        m_arready,
  input  logic [NUM_PORTS*ADDR_W-1:0] m_araddr,
  input  logic [NUM_PORTS*LEN_W-1:0]  m_arlen,
  input  logic [NUM_PORTS*ID_W-1:0]   m_arid,
  output logic [NUM_PORTS-1:0]        m_rvalid,
  input  logic [NUM_PORTS-1:0]        m_rready,
  output logic [DATA_W-1:0]           m_rdata,
  output logic [1:0]                  m_rresp,
  output logic                        m_rlast,
  output logic [ID_W-1:0]             m_rid,
  output logic                        s_arvalid,
  input  logic                        s_arready,
  output logic [ADDR_W-1:0]           s_araddr,
  output logic [LEN_W-1:0]            s_arlen,
  output logic [ID_W-1:0]             s_arid,
  input  logic                        s_rvalid,
  output logic                        s_rready,
  input  logic [DATA_W-1:0]           s_rdata,
  input  logic [1:0]                  s_rresp,
  input  logic                        s_rlast,
  input  logic [ID_W-1:0]             s_rid
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  arb_state_e       st_q;
  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] ptr_q;
  logic             pick_found;
  logic [IDX_W-1:0] pick_win;
  logic             ar_hs;
  logic             r_end;

  assign ar_hs = s_arvalid & s_arready;
  assign r_end = s_rvalid & s_rready & s_rlast;

  rr_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pick (
    .req   (m_arvalid),
    .ptr   (ptr_q),
    .found (pick_found),
    .win   (pick_win)
  );

  lock_fsm #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_found (pick_found),
    .pick_win   (pick_win),
    .ar_hs      (ar_hs),
    .r_end      (r_end),
    .st_q       (st_q),
    .sel_q      (sel_q),
    .ptr_q      (ptr_q)
  );

  rd_path_mux #(
    .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .ID_W(ID_W)
  ) u_mux (
    .st        (st_q),
    .sel       (sel_q),
    .m_arvalid (m_arvalid),
    .m_araddr  (m_araddr),
    .m_arlen   (m_arlen),
    .m_arid    (m_arid),
    .m_rready  (m_rready),
    .s_arready (s_arready),
    .s_rvalid  (s_rvalid),
    .m_arready (m_arready),
    .m_rvalid  (m_rvalid),
    .s_arvalid (s_arvalid),
    .s_araddr  (s_araddr),
    .s_arlen   (s_arlen),
    .s_arid    (s_arid),
    .s_rready  (s_rready)
  );

  // Response payload is common to all masters; only valid is steered.
  assign m_rdata = s_rdata;
  assign m_rresp = s_rresp;
  assign m_rlast = s_rlast;
  assign m_rid   = s_rid;

  AST_ARREADY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_arready)); // R3
  AST_RVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_rvalid)); // R5
  AST_NO_ADDR_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_DATA) |-> !s_arvalid); // R4
  AST_NO_ADDR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    r_end |=> !s_arvalid); // R6
  AST_GRANT_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_IDLE && pick_found) |-> m_arvalid[pick_win]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_IDLE) |-> (!s_arvalid && !s_rready && m_arready == '0 && m_rvalid == '0)); // R1
  AST_RREADY_FROM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_DATA) |-> (s_rready == m_rready[sel_q])); // R8
endmodule

// File: tb/rd_lock_arb_bench.sv
module rd_lock_arb_bench;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int IW = 4;
  localparam int DW = 32;

  logic              clk;
  logic              rst_n;
  logic [NP-1:0]     m_arvalid;
  logic [NP-1:0]     m_arready;
  logic [NP*AW-1:0]  m_araddr;
  logic [NP*LW-1:0]  m_arlen;
  logic [NP*IW-1:0]  m_arid;
  logic [NP-1:0]     m_rvalid;
  logic [NP-1:0]     m_rready;
  logic [DW-1:0]     m_rdata;
  logic [1:0]        m_rresp;
  logic              m_rlast;
  logic [IW-1:0]     m_rid;
  logic              s_arvalid;
  logic              s_arready;
  logic [AW-1:0]     s_araddr;
  logic [LW-1:0]     s_arlen;
  logic [IW-1:0]     s_arid;
  logic              s_rvalid;
  logic              s_rready;
  logic [DW-1:0]     s_rdata;
  logic [1:0]        s_rresp;
  logic              s_rlast;
  logic [IW-1:0]     s_rid;

  rd_lock_arb #(.NUM_PORTS(NP), .ADDR_W(AW), .LEN_W(LW), .ID_W(IW), .DATA_W(DW)) u_rd_lock_arb (
    .clk(clk), .rst_n(rst_n),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_arlen(m_arlen), .m_arid(m_arid), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rid(m_rid),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_arlen(s_arlen), .s_arid(s_arid), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast), .s_rid(s_rid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          port;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [3:0]  id;
    string       tag;
  } grant_t;

  grant_t      exp_q[$];
  int          total = 0;
  int          bad   = 0;
  int          cyc   = 0;
  bit          lock_busy = 0;
  int          lock_port = 0;
  bit          sl_busy = 0;
  logic [31:0] sl_addr;
  logic [7:0]  sl_len;
  logic [3:0]  sl_id;
  int          sl_beat = 0;
  bit          after1 = 0;
  bit          after2 = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: raise a master's request with its payload.
  task automatic drive_req(input int p, input logic [31:0] a, input logic [7:0] l,
                           input logic [3:0] id);
    m_araddr[p*AW +: AW] = a;
    m_arlen[p*LW +: LW]  = l;
    m_arid[p*IW +: IW]   = id;
    m_arvalid[p]         = 1'b1;
  endtask

  // Driver: push one expected grant into the scoreboard.
  task automatic expect_grant(input int p, input string tag);
    grant_t g;
    g.port = p;
    g.addr = 32'h1000 + 32'(p) * 32'h100 + 32'(cyc);
    g.len  = 8'(p + 1);
    g.id   = 4'(p + 5);
    g.tag  = tag;
    exp_q.push_back(g);
  endtask

  task automatic req_and_expect(input int p, input string tag);
    expect_grant(p, tag);
    drive_req(p, exp_q[exp_q.size()-1].addr, exp_q[exp_q.size()-1].len,
              exp_q[exp_q.size()-1].id);
  endtask

  // One clock: monitor at the falling edge, update stimulus after the rising edge.
  task automatic tick();
    bit ar_hs;
    bit r_hs;
    bit drop;
    int gp;
    bit had_after1;
    @(negedge clk);
    cyc++;
    ar_hs = s_arvalid && s_arready;
    r_hs  = s_rvalid && s_rready;
    drop  = 0;
    gp    = 0;
    if (after2) chk(s_arvalid == 1'b1, "R6", "request forwarded after idle gap", s_arvalid, 1);
    had_after1 = after1;
    if (after1) chk(s_arvalid == 1'b0, "R6", "idle cycle after last beat", s_arvalid, 0);
    after2 = had_after1 && (|m_arvalid);
    after1 = 0;
    if (lock_busy) begin
      chk(s_arvalid == 1'b0, "R4", "no address while locked", s_arvalid, 0);
      chk(m_rvalid == (s_rvalid ? NP'(1 << lock_port) : '0), "R5", "rvalid routing",
          m_rvalid, s_rvalid ? (1 << lock_port) : 0);
      chk(s_rready == m_rready[lock_port], "R8", "rready from locked port only",
          s_rready, m_rready[lock_port]);
    end
    if (ar_hs) begin
      chk($onehot(m_arready), "R3", "single arready", m_arready, 0);
      for (int i = 0; i < NP; i++) if (m_arready[i]) gp = i;
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected grant", gp, -1);
      end else begin
        grant_t e;
        e = exp_q.pop_front();
        chk(gp == e.port, e.tag, "granted port", gp, e.port);
        chk(s_araddr == e.addr, "R3", "forwarded address", s_araddr, e.addr);
        chk(s_arlen == e.len, "R3", "forwarded length", s_arlen, e.len);
        chk(s_arid == e.id, "R3", "forwarded id", s_arid, e.id);
      end
      drop = 1;
      lock_busy = 1;
      lock_port = gp;
      sl_busy = 1;
      sl_addr = s_araddr;
      sl_len  = s_arlen;
      sl_id   = s_arid;
      sl_beat = 0;
    end else if (r_hs) begin
      chk(m_rvalid[lock_port] && m_rready[lock_port], "R5", "beat seen by locked port", m_rvalid, 1 << lock_port);
      chk(m_rdata == sl_addr + 32'(sl_beat) && m_rid == sl_id && m_rlast == s_rlast,
          "R5", "beat payload", m_rdata, sl_addr + 32'(sl_beat));
      if (s_rlast) begin
        chk(sl_beat == int'(sl_len), "R5", "beat count", sl_beat + 1, int'(sl_len) + 1);
        lock_busy = 0;
        sl_busy = 0;
        after1 = 1;
      end else begin
        sl_beat++;
      end
    end
    @(posedge clk);
    #1;
    if (drop) m_arvalid[gp] = 1'b0;
    s_arready = cyc[0];
    s_rvalid  = sl_busy && (cyc % 3 != 0);
    s_rdata   = sl_addr + 32'(sl_beat);
    s_rlast   = sl_busy && (sl_beat == int'(sl_len));
    s_rid     = sl_id;
    s_rresp   = 2'b00;
    m_rready  = '1;
    if (lock_busy) m_rready[lock_port] = (cyc % 4 != 1);
  endtask

  task automatic run_drain();
    int guard = 0;
    while ((exp_q.size() != 0 || lock_busy || (|m_arvalid)) && guard < 4000) begin
      tick();
      guard++;
    end
    if (guard >= 4000) chk(0, "R2", "drain timeout", guard, 0);
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    m_arvalid = '0; m_araddr = '0; m_arlen = '0; m_arid = '0; m_rready = '1;
    s_arready = 1'b1; s_rvalid = 1'b0; s_rdata = '0; s_rresp = '0; s_rlast = 1'b0; s_rid = '0;
    sl_addr = '0; sl_len = '0; sl_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    tick();
    // R1: quiet after reset with no requests
    chk(s_arvalid == 0 && s_rready == 0, "R1", "slave side quiet", {s_arvalid, s_rready}, 0);
    chk(m_arready == '0 && m_rvalid == '0, "R1", "master side quiet", {m_arready, m_rvalid}, 0);

    // R2: all four request together; pointer starts at port 0
    for (int p = 0; p < NP; p++) req_and_expect(p, "R2");
    run_drain();

    // R7: ports 3 and 1 request, pointer at 0 -> 1 then 3, skipping 0 and 2
    req_and_expect(1, "R7");
    req_and_expect(3, "R7");
    run_drain();

    // R2: port 2 alone, then 0, 2, 3 -> wrap order 3, 0, 2
    req_and_expect(2, "R2");
    run_drain();
    req_and_expect(3, "R2");
    req_and_expect(0, "R2");
    req_and_expect(2, "R2");
    run_drain();

    // R4: new requests arrive while port 0 is locked in its response phase
    req_and_expect(0, "R4");
    while (!lock_busy) tick();
    tick();
    req_and_expect(1, "R4");
    req_and_expect(3, "R4");
    run_drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule